// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame passes the destination-address stage of a receive MAC. For each frame it takes a strobe, the 48-bit destination address, and the six low bits of the CRC computed over that address. It also takes a flag from the unicast perfect-match logic and a flag that marks a MAC control frame. One clock later it presents a verdict: accept or reject, or a bypass indication for control frames. The decision for control frames belongs to other logic.

Multicast frames are checked against a 64-bit hash table. The table is held as eight 8-bit registers that software writes through a simple write port. The three low CRC bits select the register and the next three bits select a bit inside it. Two inputs can override the normal result for every non-control frame: a two-bit filter mode (accept everything or reject everything) and a broadcast accept/reject select. Control frames are never touched by either input.

Top module: `maf_filter`

## Requirements
- R1: After reset every hash bit is 0 and `dec_valid` is 0, so a multicast frame in normal mode is rejected at any hash index until a register is written.
- R2: `dec_valid` is 1 in exactly the cycle after a cycle with `da_valid` = 1. While `dec_valid` is 0, `dec_accept` and `dec_bypass` are both 0.
- R3: A write with `reg_wr_en` = 1 loads `reg_wdata` into hash register `reg_addr` (0..7) at the next edge and leaves the other seven registers unchanged.
- R4: `crc_low[2:0]` is the number of the hash register (000 = register 0, 111 = register 7). `crc_low[5:3]` is the bit number inside that register (000 = bit 0, 111 = bit 7).
- R5: In normal mode, a multicast frame is accepted only when the selected hash bit is 1. A multicast frame has `da[40]` = 1 (the group bit, bit 0 of the first address byte `da[47:40]`) and is not all ones.
- R6: In normal mode, a broadcast frame (`da` all ones) is accepted when `bcast_accept` = 1 and rejected when it is 0, whatever the hash table holds.
- R7: In normal mode, a unicast frame (`da[40]` = 0) is accepted exactly when `ucast_hit` = 1.
- R8: With `filt_mode` = 01, every non-control frame is accepted.
- R9: With `filt_mode` = 10, every non-control frame is rejected.
- R10: A frame with `is_ctrl` = 1 always yields `dec_bypass` = 1 and `dec_accept` = 0, whatever the values of `filt_mode`, `bcast_accept`, the address and the hash table.
- R11: `filt_mode` = 00 and `filt_mode` = 11 both select normal filtering.
- R12: A lookup in the same cycle as a register write uses the table contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Hash register write strobe |
| reg_addr | input | 3 | Hash register number |
| reg_wdata | input | 8 | Hash register write data |
| filt_mode | input | 2 | 00/11 normal, 01 accept all, 10 reject all |
| bcast_accept | input | 1 | Accept (1) or reject (0) broadcast frames in normal mode |
| da_valid | input | 1 | Destination address and CRC bits are valid this cycle |
| da | input | 48 | Destination address, first byte in [47:40] |
| crc_low | input | 6 | Six low CRC bits over the destination address |
| ucast_hit | input | 1 | Unicast perfect-match result for this frame |
| is_ctrl | input | 1 | Frame is a MAC control frame |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | Frame passes the address filter |
| dec_bypass | output | 1 | Control frame; verdict left to other logic |

## Verification
The bench sweeps all 64 hash indices after writing a pattern in which every byte differs. A design that swapped the byte and bit fields of the CRC index, or reversed one of them, would accept at the wrong positions. A broadcast address also has its group bit set, so the bench sends broadcast frames against a fully set table and against an empty one. A design that checked the hash before the broadcast test would get these wrong. The bench sends control frames under accept-all with broadcast accept enabled, where an override that leaked into them would show up as an accept. It also sends a lookup in the same cycle as a write to the very bit being looked up, which catches a write-through bypass.

// File: rtl/maf_pkg.sv
package maf_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL     = 2'b00,
    MODE_ACCEPT_ALL = 2'b01,
    MODE_REJECT_ALL = 2'b10,
    MODE_NORMAL_ALT = 2'b11
  } filt_mode_e;

  typedef enum logic [1:0] {
    KIND_UNICAST   = 2'd0,
    KIND_MULTICAST = 2'd1,
    KIND_BROADCAST = 2'd2,
    KIND_CONTROL   = 2'd3
  } frame_kind_e;

  typedef struct packed {
    logic valid;
    logic accept;
    logic bypass;
  } verdict_t;

endpackage

// File: rtl/maf_hash_regs.sv
module maf_hash_regs #(
  parameter int NUM_BYTES = 8,
  parameter int BYTE_W    = 8,
  parameter int AW        = $clog2(NUM_BYTES),
  parameter int BW        = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_byte_sel,
  input  logic [BW-1:0]     rd_bit_sel,
  output logic              rd_bit
);

  logic [NUM_BYTES-1:0]             byte_we;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] table_w;

  // write decode: one enable per hash byte
  always_comb begin
    byte_we          = '0;
    byte_we[wr_addr] = wr_en;
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (byte_we[g]) begin
        q <= wr_data;
      end
    end
    assign table_w[g] = q;
  end

  // read path: byte select then bit select
  always_comb begin
    rd_bit = table_w[rd_byte_sel][rd_bit_sel];
  end

  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(byte_we));

  p_hold_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(table_w));

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> table_w[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/maf_classify.sv
module maf_classify #(
  parameter int DA_W      = 48,
  parameter int GROUP_BIT = DA_W - 8
) (
  input  logic [DA_W-1:0]            da,
  input  logic                       is_ctrl,
  output maf_pkg::frame_kind_e       kind
);
  import maf_pkg::*;

  logic all_ones;
  logic group_bit;

  always_comb begin
    all_ones  = &da;
    group_bit = da[GROUP_BIT];
    if (is_ctrl) begin
      kind = KIND_CONTROL;
    end else if (all_ones) begin
      kind = KIND_BROADCAST;
    end else if (group_bit) begin
      kind = KIND_MULTICAST;
    end else begin
      kind = KIND_UNICAST;
    end
  end

  always_comb begin
    if (kind == KIND_MULTICAST) begin
      a_mcast_group_r5: assert (group_bit && !is_ctrl);
    end
  end

endmodule

// File: rtl/maf_decide.sv
module maf_decide (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  maf_pkg::frame_kind_e kind,
  input  logic [1:0]           mode,
  input  logic                 bcast_accept,
  input  logic                 ucast_hit,
  input  logic                 hash_bit,
  output maf_pkg::verdict_t    verdict
);
  import maf_pkg::*;

  verdict_t   nxt;
  verdict_t   cur;
  filt_mode_e mode_e;
  logic       ce;

  assign mode_e = filt_mode_e'(mode);

  // next-state
  always_comb begin
    nxt = '0;
    if (in_valid) begin
      nxt.valid = 1'b1;
      if (kind == KIND_CONTROL) begin
        nxt.bypass = 1'b1;
      end else begin
        unique case (mode_e)
          MODE_ACCEPT_ALL: nxt.accept = 1'b1;
          MODE_REJECT_ALL: nxt.accept = 1'b0;
          default: begin
            unique case (kind)
              KIND_BROADCAST: nxt.accept = bcast_accept;
              KIND_MULTICAST: nxt.accept = hash_bit;
              default:        nxt.accept = ucast_hit;
            endcase
          end
        endcase
      end
    end
  end

  // clock enable: load on a new frame or to clear a stale verdict
  assign ce = in_valid | cur.valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (ce) begin
      cur <= nxt;
    end
  end

  assign verdict = cur;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> verdict.valid);

  p_valid_only_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !verdict.valid && !verdict.accept && !verdict.bypass);

  p_ctrl_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind == KIND_CONTROL) |=> verdict.bypass && !verdict.accept);

  p_accept_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind != KIND_CONTROL && mode == 2'b01) |=> verdict.accept);

  p_reject_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind != KIND_CONTROL && mode == 2'b10) |=> !verdict.accept);

  p_bcast_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind == KIND_BROADCAST && (mode == 2'b00 || mode == 2'b11))
      |=> verdict.accept == $past(bcast_accept));

  p_mcast_needs_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind == KIND_MULTICAST && (mode == 2'b00 || mode == 2'b11) && !hash_bit)
      |=> !verdict.accept);

endmodule

// File: rtl/maf_filter.sv
module maf_filter #(
  parameter int NUM_BYTES = 8,
  parameter int BYTE_W    = 8,
  parameter int DA_W      = 48,
  parameter int AW        = $clog2(NUM_BYTES),
  parameter int BW        = $clog2(BYTE_W),
  parameter int IDX_W     = AW + BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic [1:0]        filt_mode,
  input  logic              bcast_accept,
  input  logic              da_valid,
  input  logic [DA_W-1:0]   da,
  input  logic [IDX_W-1:0]  crc_low,
  input  logic              ucast_hit,
  input  logic              is_ctrl,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_bypass
);
  import maf_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic [AW-1:0]          byte_sel;
  logic [BW-1:0]          bit_sel;
  logic                   hash_bit;
  frame_kind_e            kind;
  verdict_t               verdict;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // hash index split: low field picks the byte, high field the bit
  assign byte_sel = crc_low[AW-1:0];
  assign bit_sel  = crc_low[IDX_W-1:AW];

  maf_hash_regs #(
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W),
    .AW        (AW),
    .BW        (BW)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_en       (reg_wr_en),
    .wr_addr     (reg_addr),
    .wr_data     (reg_wdata),
    .rd_byte_sel (byte_sel),
    .rd_bit_sel  (bit_sel),
    .rd_bit      (hash_bit)
  );

  maf_classify #(
    .DA_W (DA_W)
  ) u_class (
    .da      (da),
    .is_ctrl (is_ctrl),
    .kind    (kind)
  );

  maf_decide u_decide (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .in_valid     (da_valid),
    .kind         (kind),
    .mode         (filt_mode),
    .bcast_accept (bcast_accept),
    .ucast_hit    (ucast_hit),
    .hash_bit     (hash_bit),
    .verdict      (verdict)
  );

  assign dec_valid  = verdict.valid;
  assign dec_accept = verdict.accept;
  assign dec_bypass = verdict.bypass;

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> !dec_valid);

  p_ctrl_never_accepts_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    dec_bypass |-> dec_valid && !dec_accept);

endmodule

// File: tb/tb_maf_filter.sv
module tb_maf_filter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [1:0]  filt_mode;
  logic        bcast_accept;
  logic        da_valid;
  logic [47:0] da;
  logic [5:0]  crc_low;
  logic        ucast_hit;
  logic        is_ctrl;
  logic        dec_valid, dec_accept, dec_bypass;

  always #10 clk = ~clk;

  maf_filter dut (
    .clk (clk), .rst_n (rst_n),
    .reg_wr_en (reg_wr_en), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .filt_mode (filt_mode), .bcast_accept (bcast_accept),
    .da_valid (da_valid), .da (da), .crc_low (crc_low),
    .ucast_hit (ucast_hit), .is_ctrl (is_ctrl),
    .dec_valid (dec_valid), .dec_accept (dec_accept), .dec_bypass (dec_bypass)
  );

  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'h0100_5E00_0001;
  localparam logic [47:0] UC = 48'h0211_2233_4455;

  logic [7:0] m_hash [8];
  int         n_cmp = 0;
  int         n_bad = 0;
  logic       e_valid, e_acc, e_byp;
  string      e_req;
  logic [1:0] nx_mode = 2'b00;
  logic       nx_bacc = 1'b0;
  bit         done = 1'b0;

  task automatic check_now();
    n_cmp++;
    if ({dec_valid, dec_accept, dec_bypass} !== {e_valid, e_acc, e_byp}) begin
      n_bad++;
      $display("FAIL %s: v/acc/byp actual %b%b%b expected %b%b%b at %0t",
               e_req, dec_valid, dec_accept, dec_bypass, e_valid, e_acc, e_byp, $time);
    end
  endtask

  // apply one cycle of stimulus; check the previous cycle's verdict first
  task automatic step(input string req, input logic v, input logic [47:0] a,
                      input logic [5:0] c, input logic ctl, input logic uh,
                      input logic w, input logic [2:0] wa, input logic [7:0] wd);
    @(negedge clk);
    check_now();
    da_valid = v; da = a; crc_low = c; is_ctrl = ctl; ucast_hit = uh;
    reg_wr_en = w; reg_addr = wa; reg_wdata = wd;
    filt_mode = nx_mode; bcast_accept = nx_bacc;
    e_req = req;
    e_valid = v; e_acc = 1'b0; e_byp = 1'b0;
    if (v) begin
      if (ctl) e_byp = 1'b1;
      else if (nx_mode == 2'b01) e_acc = 1'b1;
      else if (nx_mode == 2'b10) e_acc = 1'b0;
      else if (a == BC) e_acc = nx_bacc;
      else if (a[40]) e_acc = m_hash[c[2:0]][c[5:3]];
      else e_acc = uh;
    end
    if (w) m_hash[wa] = wd;  // table seen by this lookup was the old one
  endtask

  task automatic idle(input string req);
    step(req, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic look(input string req, input logic [47:0] a, input logic [5:0] c,
                      input logic ctl, input logic uh);
    step(req, 1'b1, a, c, ctl, uh, 1'b0, '0, '0);
  endtask

  task automatic wr(input string req, input logic [2:0] wa, input logic [7:0] wd);
    step(req, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, wa, wd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_hash[i] = 8'h00;
    rst_n = 1'b0;
    da_valid = 0; da = '0; crc_low = '0; is_ctrl = 0; ucast_hit = 0;
    reg_wr_en = 0; reg_addr = '0; reg_wdata = '0; filt_mode = 2'b00; bcast_accept = 0;
    e_valid = 0; e_acc = 0; e_byp = 0; e_req = "R1";
    repeat (3) begin @(negedge clk); check_now(); end
    rst_n = 1'b1;
    repeat (4) idle("R1");

    // R1: empty table rejects multicast everywhere
    for (int i = 0; i < 64; i += 9) look("R1", MC, 6'(i), 1'b0, 1'b0);
    idle("R2");
    look("R2", UC, '0, 1'b0, 1'b1);
    idle("R2"); idle("R2");

    // R4: single bit, register 3 bit 5 -> index {3'd5,3'd3}
    wr("R3", 3'd3, 8'b0010_0000);
    look("R4", MC, {3'd5, 3'd3}, 1'b0, 1'b0);
    look("R4", MC, {3'd4, 3'd3}, 1'b0, 1'b0);
    look("R4", MC, {3'd5, 3'd2}, 1'b0, 1'b0);
    look("R4", MC, {3'd3, 3'd5}, 1'b0, 1'b0);

    // R3/R4/R5: distinct pattern in every byte, full sweep
    for (int k = 0; k < 8; k++) wr("R3", 3'(k), 8'((8'h01 << k) ^ (8'h3C + 8'(k * 17))));
    for (int i = 0; i < 64; i++) look("R5", MC, 6'(i), 1'b0, 1'b1);
    wr("R3", 3'd6, 8'h00);
    for (int i = 0; i < 64; i++) look("R3", MC, 6'(i), 1'b0, 1'b0);

    // R6: broadcast ignores hash
    for (int k = 0; k < 8; k++) wr("R6", 3'(k), 8'hFF);
    nx_bacc = 1'b0; look("R6", BC, 6'd0, 1'b0, 1'b0); look("R6", BC, 6'd63, 1'b0, 1'b1);
    nx_bacc = 1'b1; look("R6", BC, 6'd7, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) wr("R6", 3'(k), 8'h00);
    look("R6", BC, 6'd7, 1'b0, 1'b0);
    nx_bacc = 1'b0; look("R6", BC, 6'd7, 1'b0, 1'b1);

    // R7: unicast follows perfect-match flag
    look("R7", UC, 6'd12, 1'b0, 1'b1);
    look("R7", UC, 6'd12, 1'b0, 1'b0);
    idle("R7");

    // R8/R9: overrides
    nx_mode = 2'b01;
    look("R8", UC, 6'd1, 1'b0, 1'b0); look("R8", MC, 6'd1, 1'b0, 1'b0);
    look("R8", BC, 6'd1, 1'b0, 1'b0);
    nx_mode = 2'b10; nx_bacc = 1'b1;
    wr("R9", 3'd1, 8'hFF);
    look("R9", UC, 6'd1, 1'b0, 1'b1); look("R9", MC, 6'd1, 1'b0, 1'b0);
    look("R9", BC, 6'd1, 1'b0, 1'b0);

    // R10: control frames untouched by modes and broadcast select
    for (int m = 0; m < 4; m++) begin
      nx_mode = 2'(m);
      nx_bacc = m[0];
      look("R10", BC, 6'd9, 1'b1, 1'b1);
      look("R10", MC, 6'd9, 1'b1, 1'b0);
      look("R10", UC, 6'd9, 1'b1, 1'b1);
    end

    // R11: mode 11 is normal
    nx_mode = 2'b11; nx_bacc = 1'b0;
    look("R11", MC, {3'd2, 3'd1}, 1'b0, 1'b0);
    look("R11", MC, {3'd2, 3'd0}, 1'b0, 1'b0);
    look("R11", UC, 6'd0, 1'b0, 1'b0);
    look("R11", BC, 6'd0, 1'b0, 1'b1);

    // R12: write and lookup of the same bit in one cycle
    nx_mode = 2'b00;
    step("R12", 1'b1, MC, {3'd4, 3'd0}, 1'b0, 1'b0, 1'b1, 3'd0, 8'h10);
    look("R12", MC, {3'd4, 3'd0}, 1'b0, 1'b0);
    step("R12", 1'b1, MC, {3'd4, 3'd0}, 1'b0, 1'b0, 1'b1, 3'd0, 8'h00);
    look("R12", MC, {3'd4, 3'd0}, 1'b0, 1'b0);
    repeat (3) idle("R2");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule